// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block sits inside a switch and lets the host reach the internal PHYs over a clause-22 management bus. It needs no software bit-banging. The host writes one 32-bit control word. That word carries the PHY address, register number, direction and write data, and it sets the busy bit. The block then shifts out a complete management frame on MDC/MDIO and clears busy at the end. For a read, it places the 16 returned bits in the low half of the same word. The host polls busy and then reads the result from that word.

The block also owns the path between the PHY-side management pins and an external management host. While the master-enable bit is clear, the external host's MDC and MDIO pass straight through to the PHYs. Once master-enable is set, the external path is cut off: it sees an idle-high MDIO, and it can no longer move the PHY-side clock or data. Only one of the two paths is ever connected to the PHYs.

The host software maps user ports 1 to 5 to PHY addresses 0 to 4 and writes that address into the PHY field. The block itself sends any 5-bit address it is given.

Top module: `mdio_ctl_top`

## Requirements
- R1: After reset the control word reads 0, the master is disabled, and the PHY-side pins follow the external management host.
- R2: A write transaction produces a 64-bit frame, sent MSB first, at indices 0 to 63:
  - indices 0 to 31: preamble of 32 ones;
  - indices 32 to 33: start pattern 01;
  - indices 34 to 35: opcode 01;
  - indices 36 to 40: the 5-bit PHY address;
  - indices 41 to 45: the 5-bit register number;
  - indices 46 to 47: turnaround 10;
  - indices 48 to 63: the 16 data bits.
  MDIO is driven for all 64 bits.
- R3: A read transaction sends opcode 10 at indices 34 to 35. The master drives MDIO only for indices 0 to 45. It releases MDIO (output enable 0) for the two turnaround bits and the 16 data bits, and it samples the data bits from the PHY.
- R4: The control word layout is:
  - bit 31: busy;
  - bit 30: master enable;
  - bits 29:28: plain storage;
  - bits 27:26: operation code (01 write, 10 read);
  - bits 25:21: PHY address;
  - bits 20:16: register number;
  - bits 15:0: data.
  A write that starts a transaction shows busy = 1 one cycle later. Busy clears when the last frame bit completes. After a read, bits 15:0 hold the received data, first-received bit in bit 15.
- R5: MDC is low while idle. During a frame MDC is high for DIV/2 system cycles and low for DIV/2 cycles (DIV defaults to 64). The master changes MDIO only together with a falling MDC edge.
- R6: A control-word write while busy is 1 is ignored. It changes no field and starts no frame.
- R7: A write with busy set starts nothing when any of these holds:
  - the register number is at or above REG_LIMIT (default 29);
  - the operation code is not 01 or 10.
  In that case busy reads 0 next cycle and no MDC edge follows. REG_LIMIT-1 is accepted.
- R8: A write with busy set but master enable clear starts nothing.
- R9: With master enable clear, the PHY-side MDC, MDIO output and MDIO output enable equal the external host's signals, and the external host sees the PHY-side MDIO input.
- R10: With master enable set, the external MDC and MDIO have no effect on the PHY-side pins, and the external host sees MDIO = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write value |
| reg_rdata | output | 32 | Control word read value |
| ext_mdc | input | 1 | MDC from the external management host |
| ext_mdio_out | input | 1 | MDIO value driven by the external host |
| ext_mdio_oe | input | 1 | External host MDIO output enable |
| ext_mdio_in | output | 1 | MDIO value returned to the external host |
| phy_mdc | output | 1 | MDC toward the internal PHYs |
| phy_mdio_o | output | 1 | MDIO output toward the PHYs |
| phy_mdio_oe | output | 1 | MDIO output enable toward the PHYs |
| phy_mdio_i | input | 1 | MDIO input from the PHYs |

## Verification
The hardest case to reach from the ports is a control-word write that arrives in the middle of a running frame. The bench starts a write transaction, waits several hundred cycles, and then issues a second busy-setting word with different fields. It then confirms three things:
- the fields read back unchanged, both at once and after completion;
- the PHY model decodes exactly one frame;
- the scoreboard queue is empty.

Read data only comes back if the bench's PHY model drives MDIO on MDC falling edges during the released window. The bench therefore decodes the opcode live and answers with a value derived from the address and register.

// File: rtl/mdio_ctl_pkg.sv
// Package: shared constants and the frame builder for the management master.
// Assumes clause-22 frames only: 5-bit PHY and register fields, 16-bit data.
package mdio_ctl_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;

    // Control word field positions
    localparam int BIT_BUSY   = 31;
    localparam int BIT_EN     = 30;
    localparam int OP_LO      = 26;
    localparam int PHY_LO     = 21;
    localparam int REG_LO     = 16;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    // Builds the serial frame, index 0 in the MSB
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              rd,
        input logic [PHY_W-1:0]  phy,
        input logic [REG_W-1:0]  rg,
        input logic [DATA_W-1:0] dat
    );
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] payload;
        op      = rd ? OP_READ : OP_WRITE;
        ta      = rd ? 2'b11 : 2'b10;
        payload = rd ? {DATA_W{1'b1}} : dat;
        return {32'hFFFF_FFFF, 2'b01, op, phy, rg, ta, payload};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
// MDC divider: while run is high, produces MDC at clk/DIV with DIV/2 high
// and DIV/2 low, starting low. rise_tick / fall_tick flag the cycle whose
// closing edge raises / lowers MDC. Assumes DIV even and at least 4.
module mdio_clkdiv #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] HALF_M1 = CW'(DIV / 2 - 1);
    localparam logic [CW-1:0] LAST    = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign rise_tick = run && (cnt_q == HALF_M1);
    assign fall_tick = run && (cnt_q == LAST);

    // Phase counter and MDC level
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= fall_tick ? '0 : cnt_q + 1'b1;
            if (rise_tick) mdc <= 1'b1;
            if (fall_tick) mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: loads a 64-bit frame on start, presents one bit per MDC
// period (advancing on falling ticks) and samples read data on rising ticks.
// Assumes start is only pulsed while idle.
module mdio_frame_seq
    import mdio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [PHY_W-1:0]  start_phy,
    input  logic [REG_W-1:0]  start_reg,
    input  logic [DATA_W-1:0] start_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              active,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] TA_I     = IW'(TA_IDX);
    localparam logic [IW-1:0] DATA_I   = IW'(DATA_IDX);

    logic [FRAME_BITS-1:0] tx_q;
    logic [IW-1:0]         idx_q;
    logic                  rd_q;

    assign done    = active && fall_tick && (idx_q == LAST_IDX);
    assign mdio_o  = active ? tx_q[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = active && (!rd_q || (idx_q < TA_I));

    // Frame shift register, bit index and activity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '1;
            idx_q  <= '0;
            rd_q   <= 1'b0;
            active <= 1'b0;
        end else if (start) begin
            tx_q   <= build_frame(start_rd, start_phy, start_reg, start_data);
            idx_q  <= '0;
            rd_q   <= start_rd;
            active <= 1'b1;
        end else if (active && fall_tick) begin
            if (idx_q == LAST_IDX) begin
                active <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b1};
            end
        end
    end

    // Read data capture on rising MDC during the data window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (active && rd_q && rise_tick && (idx_q >= DATA_I)) begin
            rx_data <= {rx_data[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_passthru_mux.sv
// Passthrough mux: with sel_master clear the external host owns the PHY-side
// pins; with it set the internal master does and the external host sees an
// idle-high MDIO. Purely combinational.
module mdio_passthru_mux (
    input  logic sel_master,
    input  logic mst_mdc,
    input  logic mst_mdio_o,
    input  logic mst_mdio_oe,
    input  logic ext_mdc,
    input  logic ext_mdio_out,
    input  logic ext_mdio_oe,
    input  logic phy_mdio_i,
    output logic phy_mdc,
    output logic phy_mdio_o,
    output logic phy_mdio_oe,
    output logic ext_mdio_in
);
    // Route one management source to the PHY pins
    always_comb begin
        if (sel_master) begin
            phy_mdc     = mst_mdc;
            phy_mdio_o  = mst_mdio_o;
            phy_mdio_oe = mst_mdio_oe;
            ext_mdio_in = 1'b1;
        end else begin
            phy_mdc     = ext_mdc;
            phy_mdio_o  = ext_mdio_out;
            phy_mdio_oe = ext_mdio_oe;
            ext_mdio_in = phy_mdio_i;
        end
    end
endmodule

// File: rtl/mdio_ctl_top.sv
// Top: holds the self-clearing control word, qualifies transaction starts
// (enable, legal opcode, register number below REG_LIMIT, not busy) and ties
// the divider, sequencer and passthrough mux together.
// Assumes the host polls busy before issuing the next transaction.
module mdio_ctl_top
    import mdio_ctl_pkg::*;
#(
    parameter int DIV       = 64,
    parameter int REG_LIMIT = 29
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ext_mdc,
    input  logic        ext_mdio_out,
    input  logic        ext_mdio_oe,
    output logic        ext_mdio_in,
    output logic        phy_mdc,
    output logic        phy_mdio_o,
    output logic        phy_mdio_oe,
    input  logic        phy_mdio_i
);
    logic              busy_q;
    logic              en_q;
    logic [1:0]        spare_q;
    logic [1:0]        op_q;
    logic [PHY_W-1:0]  phy_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] data_q;

    logic              mst_mdc, mst_mdio_o, mst_mdio_oe;
    logic              rise_tick, fall_tick;
    logic              seq_active, seq_done;
    logic [DATA_W-1:0] rx_data;

    logic [1:0]        w_op;
    logic [REG_W-1:0]  w_reg;
    logic              w_op_ok;
    logic              w_go;
    logic              accept;
    logic              start;

    assign w_op    = reg_wdata[OP_LO +: 2];
    assign w_reg   = reg_wdata[REG_LO +: REG_W];
    assign w_op_ok = (w_op == OP_WRITE) || (w_op == OP_READ);
    assign w_go    = reg_wdata[BIT_BUSY] && reg_wdata[BIT_EN] && w_op_ok
                     && (32'(w_reg) < REG_LIMIT);
    assign accept  = reg_wr_en && !busy_q;
    assign start   = accept && w_go;

    assign reg_rdata = {busy_q, en_q, spare_q, op_q, phy_q, reg_q, data_q};

    // Control word storage, busy set on start and cleared on frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            en_q    <= 1'b0;
            spare_q <= '0;
            op_q    <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            data_q  <= '0;
        end else if (accept) begin
            busy_q  <= w_go;
            en_q    <= reg_wdata[BIT_EN];
            spare_q <= reg_wdata[29:28];
            op_q    <= w_op;
            phy_q   <= reg_wdata[PHY_LO +: PHY_W];
            reg_q   <= w_reg;
            data_q  <= reg_wdata[DATA_W-1:0];
        end else if (busy_q && seq_done) begin
            busy_q <= 1'b0;
            if (op_q == OP_READ) data_q <= rx_data;
        end
    end

    mdio_clkdiv #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (seq_active),
        .mdc       (mst_mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_rd   (w_op == OP_READ),
        .start_phy  (reg_wdata[PHY_LO +: PHY_W]),
        .start_reg  (w_reg),
        .start_data (reg_wdata[DATA_W-1:0]),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (phy_mdio_i),
        .active     (seq_active),
        .mdio_o     (mst_mdio_o),
        .mdio_oe    (mst_mdio_oe),
        .done       (seq_done),
        .rx_data    (rx_data)
    );

    mdio_passthru_mux u_mux (
        .sel_master   (en_q),
        .mst_mdc      (mst_mdc),
        .mst_mdio_o   (mst_mdio_o),
        .mst_mdio_oe  (mst_mdio_oe),
        .ext_mdc      (ext_mdc),
        .ext_mdio_out (ext_mdio_out),
        .ext_mdio_oe  (ext_mdio_oe),
        .phy_mdio_i   (phy_mdio_i),
        .phy_mdc      (phy_mdc),
        .phy_mdio_o   (phy_mdio_o),
        .phy_mdio_oe  (phy_mdio_oe),
        .ext_mdio_in  (ext_mdio_in)
    );
endmodule

// File: rtl/mdio_ctl_chk.sv
// Checker: temporal properties of the management master, bound to the top.
module mdio_ctl_chk #(
    parameter int REG_LIMIT = 29
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        busy,
    input logic        en,
    input logic        mst_mdc,
    input logic        mst_mdio_o,
    input logic        phy_mdc,
    input logic        ext_mdc,
    input logic        ext_mdio_in
);
    // R5: MDC rests low outside a frame
    a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mst_mdc);

    // R5: master data moves only with a falling MDC edge inside a frame
    a_r5_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mst_mdio_o)) |-> $fell(mst_mdc));

    // R6: fields hold while a frame runs
    a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(reg_rdata[30:16]));

    // R7: an out-of-range register number never raises busy
    a_r7_reg_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy && reg_wdata[31] && (32'(reg_wdata[20:16]) >= REG_LIMIT))
        |=> !busy);

    // R8: no start without master enable
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy && !reg_wdata[30]) |=> !busy);

    // R9: passthrough clock while disabled
    a_r9_pass_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (phy_mdc == ext_mdc));

    // R10: external host isolated while enabled
    a_r10_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (ext_mdio_in && (phy_mdc == mst_mdc)));
endmodule

bind mdio_ctl_top mdio_ctl_chk #(.REG_LIMIT(REG_LIMIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .busy        (busy_q),
    .en          (en_q),
    .mst_mdc     (mst_mdc),
    .mst_mdio_o  (mst_mdio_o),
    .phy_mdc     (phy_mdc),
    .ext_mdc     (ext_mdc),
    .ext_mdio_in (ext_mdio_in)
);

// File: tb/sim_mdio_ctl_top.sv
module sim_mdio_ctl_top;
    localparam int DIV   = 64;
    localparam int LIMIT = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_mdc = 1'b0, ext_mdio_out = 1'b1, ext_mdio_oe = 1'b0;
    logic        ext_mdio_in;
    logic        phy_mdc, phy_mdio_o, phy_mdio_oe, phy_mdio_i;
    logic        tb_phy_i = 1'b1;
    logic        phy_reply = 1'b1;
    logic        mon_on = 1'b0;

    int checks = 0;
    int errors = 0;
    int frames = 0;

    typedef struct {
        bit       rd;
        bit [4:0] phy;
        bit [4:0] rg;
        bit [15:0] dat;
    } exp_t;
    exp_t q[$];

    assign phy_mdio_i = mon_on ? phy_reply : tb_phy_i;

    always #5 clk = ~clk;

    mdio_ctl_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ext_mdc(ext_mdc), .ext_mdio_out(ext_mdio_out),
        .ext_mdio_oe(ext_mdio_oe), .ext_mdio_in(ext_mdio_in), .phy_mdc(phy_mdc),
        .phy_mdio_o(phy_mdio_o), .phy_mdio_oe(phy_mdio_oe), .phy_mdio_i(phy_mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] reply_of(input logic [4:0] phy, input logic [4:0] rg);
        return {~phy, rg, 6'h2D};
    endfunction

    function automatic logic [31:0] word(input bit busy, input bit en, input logic [1:0] op,
                                         input logic [4:0] phy, input logic [4:0] rg,
                                         input logic [15:0] dat);
        return {busy, en, 2'b00, op, phy, rg, dat};
    endfunction

    // Monitor / PHY model: decodes frames on rising MDC and pops the scoreboard
    logic [63:0] fb, fo;
    int bcnt = 0;
    always @(posedge phy_mdc) begin
        if (mon_on) begin
            fb[63-bcnt] = phy_mdio_o;
            fo[63-bcnt] = phy_mdio_oe;
            bcnt++;
            if (bcnt == 64) begin
                exp_t e;
                logic [63:0] ev;
                bcnt = 0;
                frames++;
                if (q.size() == 0) begin
                    check(0, "R6 unexpected frame", fb, 64'h0);
                end else begin
                    e = q.pop_front();
                    ev = {32'hFFFF_FFFF, 2'b01, e.rd ? 2'b10 : 2'b01, e.phy, e.rg, 2'b10, e.dat};
                    if (!e.rd) begin
                        check(fb == ev, "R2 write frame bits", fb, ev);
                        check(fo == '1, "R2 write frame drive", fo, '1);
                    end else begin
                        check(fb[63:18] == ev[63:18], "R3 read frame header", {18'h0, fb[63:18]},
                              {18'h0, ev[63:18]});
                        check(fo == {46'h3FFF_FFFF_FFFF, 18'h0}, "R3 read release window",
                              fo, {46'h3FFF_FFFF_FFFF, 18'h0});
                    end
                end
            end
        end
    end

    // PHY model drives read data after each falling MDC in the data window
    always @(negedge phy_mdc) begin
        if (mon_on) begin
            if (bcnt >= 48 && fb[63-34] == 1'b1 && fb[63-35] == 1'b0)
                phy_reply = reply_of(fb[63-36 -: 5], fb[63-41 -: 5])[15-(bcnt-48)];
            else
                phy_reply = 1'b1;
        end
    end

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (reg_rdata[31] && n < 64 * DIV + 100) begin
            @(negedge clk);
            n++;
        end
        check(!reg_rdata[31], req, {63'h0, reg_rdata[31]}, 64'h0);
    endtask

    // Driver: issues one transaction and pushes its expectation
    task automatic txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] dat);
        exp_t e;
        e.rd = rd; e.phy = phy; e.rg = rg; e.dat = dat;
        q.push_back(e);
        wr(word(1, 1, rd ? 2'b10 : 2'b01, phy, rg, dat));
        check(reg_rdata[31] == 1'b1, "R4 busy set", {63'h0, reg_rdata[31]}, 64'h1);
        wait_idle("R4 busy clears");
        if (rd)
            check(reg_rdata[15:0] == reply_of(phy, rg), "R4 read data",
                  {48'h0, reg_rdata[15:0]}, {48'h0, reply_of(phy, rg)});
        else
            check(reg_rdata[15:0] == dat, "R4 write data kept",
                  {48'h0, reg_rdata[15:0]}, {48'h0, dat});
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        int hi;
        int lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(reg_rdata == 32'h0, "R1 reset word", {32'h0, reg_rdata}, 64'h0);
        ext_mdc = 1'b1;
        #1;
        check(phy_mdc == 1'b1, "R1 reset passthrough", {63'h0, phy_mdc}, 64'h1);

        // R9: passthrough with master disabled
        ext_mdio_out = 1'b0; ext_mdio_oe = 1'b1; tb_phy_i = 1'b0;
        #1;
        check({phy_mdc, phy_mdio_o, phy_mdio_oe, ext_mdio_in} == 4'b1010, "R9 passthrough",
              {60'h0, phy_mdc, phy_mdio_o, phy_mdio_oe, ext_mdio_in}, 64'hA);

        // R10: enable master, external host isolated
        wr(word(0, 1, 2'b01, 5'd0, 5'd0, 16'h0));
        ext_mdc = 1'b1; tb_phy_i = 1'b0;
        #1;
        check({phy_mdc, phy_mdio_oe, ext_mdio_in} == 3'b001, "R10 isolation",
              {61'h0, phy_mdc, phy_mdio_oe, ext_mdio_in}, 64'h1);
        ext_mdc = 1'b0; ext_mdio_oe = 1'b0; tb_phy_i = 1'b1;
        mon_on = 1'b1;

        // R5: MDC shape on a write frame, then R2 via the monitor
        begin
            exp_t e;
            e.rd = 0; e.phy = 5'd3; e.rg = 5'd4; e.dat = 16'hA5C3;
            q.push_back(e);
            wr(word(1, 1, 2'b01, 5'd3, 5'd4, 16'hA5C3));
            check(phy_mdc == 1'b0, "R5 MDC starts low", {63'h0, phy_mdc}, 64'h0);
            while (!phy_mdc) @(negedge clk);
            hi = 0;
            while (phy_mdc) begin @(negedge clk); hi++; end
            lo = 0;
            while (!phy_mdc) begin @(negedge clk); lo++; end
            check(hi == DIV / 2, "R5 MDC high width", 64'(hi), 64'(DIV / 2));
            check(lo == DIV / 2, "R5 MDC low width", 64'(lo), 64'(DIV / 2));
            wait_idle("R4 busy clears");
            check(phy_mdc == 1'b0, "R5 MDC idle low", {63'h0, phy_mdc}, 64'h0);
        end

        // R2/R3/R4: several patterns
        txn(0, 5'd0, 5'd0, 16'h0000);
        txn(0, 5'd31, 5'd17, 16'hFFFF);
        txn(1, 5'd0, 5'd1, 16'h0);
        txn(1, 5'd4, 5'd28, 16'h0);          // R7 boundary: REG_LIMIT-1 accepted

        // R7: register number at the limit starts nothing
        f0 = frames;
        wr(word(1, 1, 2'b01, 5'd2, 5'(LIMIT), 16'h1111));
        check(reg_rdata[31] == 1'b0, "R7 limit no busy", {63'h0, reg_rdata[31]}, 64'h0);
        repeat (3 * DIV) @(negedge clk);
        check(frames == f0 && bcnt == 0, "R7 limit no frame", 64'(frames), 64'(f0));

        // R7: illegal opcode starts nothing
        wr(word(1, 1, 2'b11, 5'd2, 5'd3, 16'h2222));
        check(reg_rdata[31] == 1'b0, "R7 bad opcode no busy", {63'h0, reg_rdata[31]}, 64'h0);
        repeat (3 * DIV) @(negedge clk);
        check(frames == f0 && bcnt == 0, "R7 bad opcode no frame", 64'(frames), 64'(f0));

        // R6: write during busy ignored
        begin
            exp_t e;
            e.rd = 0; e.phy = 5'd7; e.rg = 5'd9; e.dat = 16'h1234;
            q.push_back(e);
            wr(word(1, 1, 2'b01, 5'd7, 5'd9, 16'h1234));
            repeat (500) @(negedge clk);
            wr(word(1, 1, 2'b10, 5'd31, 5'd2, 16'hBEEF));
            check(reg_rdata[29:0] == word(0, 1, 2'b01, 5'd7, 5'd9, 16'h1234)[29:0],
                  "R6 fields unchanged", {32'h0, reg_rdata}, {32'h0, word(1, 1, 2'b01, 5'd7, 5'd9, 16'h1234)});
            wait_idle("R6 busy clears");
            check(reg_rdata[29:0] == word(0, 1, 2'b01, 5'd7, 5'd9, 16'h1234)[29:0],
                  "R6 fields after frame", {32'h0, reg_rdata}, {32'h0, word(0, 1, 2'b01, 5'd7, 5'd9, 16'h1234)});
            repeat (3 * DIV) @(negedge clk);
            check(bcnt == 0 && q.size() == 0, "R6 single frame", 64'(q.size()), 64'h0);
        end

        // R8: busy without enable starts nothing, and passthrough returns
        mon_on = 1'b0;
        f0 = frames;
        wr(word(1, 0, 2'b01, 5'd1, 5'd1, 16'h3333));
        check(reg_rdata[31:30] == 2'b00, "R8 no start without enable",
              {62'h0, reg_rdata[31:30]}, 64'h0);
        ext_mdc = 1'b1; tb_phy_i = 1'b0;
        #1;
        check(phy_mdc == 1'b1 && ext_mdio_in == 1'b0, "R9 passthrough restored",
              {62'h0, phy_mdc, ext_mdio_in}, 64'h2);
        check(frames == f0, "R8 no frame", 64'(frames), 64'(f0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule